// File: doc/BRIEF.md
# Clock Generator Configuration Slave (SMBus)

This block is the control port of a clock synthesizer. It listens on a two-wire SMBus, answers only its own device address, and holds ten 8-bit configuration bytes. These bytes set spread mode, output enables, stop behaviour and the PLL divider source. The register contents leave the block as one flat parallel vector, and the bit that selects the PLL divider source is also given as a separate pin.

A write transfer carries the address byte first, then a command byte and a byte count. The block acknowledges both bytes and ignores their values. The data bytes that follow land in byte 0, byte 1 and onward. A read transfer returns byte 0 first, and the index moves forward on each master acknowledge. Some fields are not stored. Two bits of byte 0 mirror the strap pins, and one bit of byte 0 shows the combined PCI-stop state. Byte 6 is a fixed signature. Reserved bits hold no state.

SCL and SDA are sampled by a system clock that runs at least 8 times faster than SCL. SDA is modelled as an open-drain pad: the block only pulls the line low, through `sda_oe`.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The block acknowledges only the 8-bit address bytes 0xD2 (write) and 0xD3 (read), by pulling SDA low in the ninth clock. It does not answer any other address byte and then stays off the bus until the next START.
- R2: In a write, the block acknowledges the byte after the address (command) and the byte after that (count), whatever their values. Each later byte is acknowledged and stored into byte 0, byte 1 and so on, in order.
- R3: Byte 0 reads back as {w7, w6, w5, 0, w3 AND pci_halt_n, strap_hi, strap_lo, 0}, where w is the last value written to byte 0.
- R4: Byte 6 always reads 0x13 (revision 1 in bits 7:4, vendor 3 in bits 3:0). A write to byte 6 is acknowledged and has no effect.
- R5: After reset the bytes read 0: 0x00|straps, 1: 0x06, 2: 0x77, 3: 0xDF, 4: 0x3F, 5: 0x40, 6: 0x13, 7: 0x00, 8: 0x00, 9: 0x00.
- R6: The writable bit masks are 0: 0xE8, 1: 0x76, 2: 0xF7, 3: 0xFF, 4: 0xBF, 5: 0xF5, 6: 0x00, 7: 0x00, 8: 0x7F, 9: 0x7F. Bits outside a mask read 0 and ignore writes.
- R7: In a read, byte 0 is sent first, MSB first. After each master ACK the next byte follows. After a master NACK, `sda_oe` is 0.
- R8: The byte index wraps from 9 to 0, in both reads and writes.
- R9: A repeated START or a STOP in the middle of a byte ends the transfer. Bytes already completed stay written, and the partial byte is discarded.
- R10: `pll_src_sel` equals bit 0 of byte 9.
- R11: The stored bytes change only when a data byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_hi | input | 1 | Upper frequency-select strap |
| strap_lo | input | 1 | Lower frequency-select strap |
| pci_halt_n | input | 1 | External PCI stop pin, active low |
| cfg_view | output | 80 | Read view of all bytes, byte i at bits 8i+7:8i |
| pll_src_sel | output | 1 | 1: PLL dividers taken from bytes 8/9 |

## Verification
Every possible address byte is sent, and only 0xD2 and 0xD3 must draw an acknowledge. Full ten-byte writes use three patterns: all ones, all zeros and an arithmetic sequence. All ones exposes any reserved bit that is stored, and all zeros exposes any bit stuck at its default. The arithmetic sequence gives each byte a different value, so a shifted byte index or a dropped command or count byte shows up.

All eight strap and pin combinations are read back, with the stored stop bit both set and cleared. This separates the mirrored bits from the stored ones. Twelve-byte transfers check the index wrap. Transfers cut off by a repeated START and by a STOP check that the finished bytes are kept and the partial byte is dropped.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int          NREG    = 10;
  localparam int          SIG_IDX = 6;
  localparam logic [7:0]  SIG_VAL = 8'h13;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CMD, PH_CNT, PH_WR, PH_RD} phase_t;

  // bits of each byte that hold state
  function automatic logic [7:0] wr_mask(input int i);
    case (i)
      0:       return 8'hE8;
      1:       return 8'h76;
      2:       return 8'hF7;
      3:       return 8'hFF;
      4:       return 8'hBF;
      5:       return 8'hF5;
      8, 9:    return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      1:       return 8'h06;
      2:       return 8'h77;
      3:       return 8'hDF;
      4:       return 8'h3F;
      5:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else if (g == 0) begin
          scl_q[g] <= scl_in;
          sda_q[g] <= sda_in;
        end else begin
          scl_q[g] <= scl_q[g-1];
          sda_q[g] <= sda_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDXW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rd_byte,
  output logic [IDXW-1:0] idx,
  output logic            wr_en,
  output logic [7:0]      wr_data,
  output logic            sda_oe
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NREG - 1);

  phase_t          ph, ph_n;
  logic [3:0]      bc, bc_n;
  logic [7:0]      sh, sh_n, rs, rs_n;
  logic [IDXW-1:0] idx_n, idx_inc;
  logic            oe_n;
  logic [2:0]      bsel;

  assign idx_inc = (idx == LAST) ? '0 : idx + 1'b1;
  assign bsel    = 3'(4'd7 - bc);
  assign wr_data = sh;

  always_comb begin
    ph_n  = ph;
    bc_n  = bc;
    sh_n  = sh;
    rs_n  = rs;
    idx_n = idx;
    oe_n  = sda_oe;
    wr_en = 1'b0;
    if (stop_det) begin
      ph_n = PH_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      ph_n = PH_ADDR;
      bc_n = '0;
      oe_n = 1'b0;
    end else if (ph != PH_IDLE) begin
      if (scl_rise) begin
        bc_n = bc + 1'b1;
        if (bc < 4'd8) begin
          sh_n = {sh[6:0], sda_s};
        end else if (ph == PH_RD) begin
          if (sda_s) ph_n = PH_IDLE;       // master NACK
          else       idx_n = idx_inc;
        end
      end else if (scl_fall) begin
        if (bc == 4'd8) begin
          case (ph)
            PH_ADDR: begin
              if (sh[7:1] == DEV_ADDR) begin
                oe_n  = 1'b1;
                idx_n = '0;
              end else begin
                ph_n = PH_IDLE;
              end
            end
            PH_CMD, PH_CNT: oe_n = 1'b1;
            PH_WR: begin
              oe_n  = 1'b1;
              wr_en = 1'b1;
              idx_n = idx_inc;
            end
            default: oe_n = 1'b0;          // let master acknowledge
          endcase
        end else if (bc == 4'd9) begin
          bc_n = '0;
          case (ph)
            PH_ADDR: ph_n = sh[0] ? PH_RD : PH_CMD;
            PH_CMD:  ph_n = PH_CNT;
            PH_CNT:  ph_n = PH_WR;
            default: ph_n = ph;
          endcase
          if (ph_n == PH_RD) begin
            rs_n = rd_byte;
            oe_n = ~rd_byte[7];
          end else begin
            oe_n = 1'b0;
          end
        end else if (ph == PH_RD && bc != 4'd0) begin
          oe_n = ~rs[bsel];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      bc     <= '0;
      sh     <= '0;
      rs     <= '0;
      idx    <= '0;
      sda_oe <= 1'b0;
    end else begin
      ph     <= ph_n;
      bc     <= bc_n;
      sh     <= sh_n;
      rs     <= rs_n;
      idx    <= idx_n;
      sda_oe <= oe_n;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && $past(ph) == PH_IDLE) |-> !sda_oe);                    // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);                                                            // R8
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || stop_det || start_det || $past(stop_det) || $past(start_det))); // R7
  AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ph == PH_WR));                                                // R2
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
  import clkcfg_pkg::*;
#(
  parameter int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              pci_halt_n,
  output logic [8*NREG-1:0] view
);
  logic [NREG-1:0][7:0] store;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] MSK = wr_mask(g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          store[g] <= rst_val(g) & MSK;
        else if (wr_en && wr_idx == IDXW'(g))
          store[g] <= (store[g] & ~MSK) | (wr_data & MSK);
      end
      if (g == 0) begin : g_stat
        assign view[7:0] = {store[0][7:5], 1'b0, store[0][3] & pci_halt_n,
                            strap_hi, strap_lo, 1'b0};
      end else if (g == SIG_IDX) begin : g_sig
        assign view[8*g +: 8] = SIG_VAL;
      end else begin : g_plain
        assign view[8*g +: 8] = store[g] & MSK;
      end
    end
  endgenerate

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store));                                              // R11
  AST_SIG_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDXW'(SIG_IDX)) |=> $stable(store));                 // R4
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              pci_halt_n,
  output logic [8*NREG-1:0] cfg_view,
  output logic              pll_src_sel
);
  localparam int IDXW = $clog2(NREG);

  logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDXW-1:0] idx;
  logic            wr_en;
  logic [7:0]      wr_data, rd_byte;

  clkcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_in, .sda_in, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  clkcfg_link #(.DEV_ADDR(DEV_ADDR), .IDXW(IDXW)) u_link (
    .clk, .rst_n, .scl_s, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_byte, .idx, .wr_en, .wr_data, .sda_oe
  );

  clkcfg_bank #(.IDXW(IDXW)) u_bank (
    .clk, .rst_n, .wr_en, .wr_idx(idx), .wr_data,
    .strap_hi, .strap_lo, .pci_halt_n, .view(cfg_view)
  );

  assign rd_byte     = cfg_view[{idx, 3'b000} +: 8];
  assign pll_src_sel = cfg_view[8*9];

  AST_PLL_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDXW'(9)) |=> (pll_src_sel == $past(wr_data[0])));      // R10
endmodule

// File: tb/clkcfg_smbus_slave_test.sv
module clkcfg_smbus_slave_test;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic s2 = 1'b1, s1 = 1'b0, pin = 1'b1;
  logic sda_oe, pll_sel;
  logic [79:0] view;
  wire  sda_bus = m_sda & ~sda_oe;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] est [10];

  always #5 clk = ~clk;

  clkcfg_smbus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .strap_hi(s2), .strap_lo(s1), .pci_halt_n(pin), .cfg_view(view), .pll_src_sel(pll_sel)
  );

  function automatic logic [7:0] msk(input int i);
    logic [7:0] t [10] = '{8'hE8, 8'h76, 8'hF7, 8'hFF, 8'hBF, 8'hF5, 8'h00, 8'h00, 8'h7F, 8'h7F};
    return t[i];
  endfunction

  function automatic logic [7:0] ev(input int i);
    if (i == 0) return {est[0][7:5], 1'b0, est[0][3] & pin, s2, s1, 1'b0};
    if (i == 6) return 8'h13;
    return est[i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half(); repeat (Q) @(negedge clk); endtask
  task automatic m_start(); m_sda = 1'b1; half(); scl = 1'b1; half(); m_sda = 1'b0; half(); scl = 1'b0; half(); endtask
  task automatic m_stop(); m_sda = 1'b0; half(); scl = 1'b1; half(); m_sda = 1'b1; half(); endtask
  task automatic m_bit(input logic b, output logic s);
    m_sda = b; half(); scl = 1'b1; half(); s = sda_bus; half(); scl = 1'b0; half();
  endtask
  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic m_rbyte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(1'b1, d[i]);
    m_bit(nack, s);
  endtask

  task automatic view_all(input string tag);
    for (int i = 0; i < 10; i++) check(tag, view[8*i +: 8], ev(i));
  endtask

  // write n bytes starting at byte 0, with index wrap in the model
  task automatic wr_seq(input int n, input int pat);
    logic a; logic [7:0] d;
    m_start();
    m_wbyte(8'hD2, a);  check("R1 write addr ack", a, 1);
    m_wbyte(8'h3C, a);  check("R2 command ack", a, 1);
    m_wbyte(8'h0A, a);  check("R2 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      d = (pat == 0) ? 8'hFF : (pat == 1) ? 8'h00 : 8'(i * 37 + 5);
      m_wbyte(d, a);
      check("R2 data ack", a, 1);
      est[i % 10] = d & msk(i % 10);
    end
    m_stop();
  endtask

  task automatic rd_seq(input int n);
    logic a; logic [7:0] d;
    m_start();
    m_wbyte(8'hD3, a); check("R1 read addr ack", a, 1);
    for (int i = 0; i < n; i++) begin
      m_rbyte(i == n - 1, d);
      check((i >= 10) ? "R8 read wrap" : "R7 read data", d, ev(i % 10));
    end
    half();
    check("R7 released after NACK", sda_oe, 0);
    m_stop();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a; logic [7:0] d;
    est = '{8'h00, 8'h06, 8'h77, 8'hDF, 8'h3F, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    half();
    view_all("R5 reset value");
    check("R7 idle sda", sda_oe, 0);

    // every address byte
    for (int ad = 0; ad < 256; ad++) begin
      m_start();
      m_wbyte(8'(ad), a);
      check("R1 address decode", a, (ad == 8'hD2 || ad == 8'hD3));
      if (a && ad[0]) begin
        m_rbyte(1'b1, d);
        check("R7 first read byte", d, ev(0));
      end
      m_stop();
    end

    for (int p = 0; p < 3; p++) begin
      wr_seq(10, p);
      view_all("R6 masked write");
      check("R10 pll select", pll_sel, est[9][0]);
      rd_seq(10);
    end

    // straps and pin against stored stop bit
    for (int st = 0; st < 2; st++) begin
      est[0] = st ? 8'h08 : 8'h00;
      m_start(); m_wbyte(8'hD2, a); m_wbyte(8'h00, a); m_wbyte(8'h01, a);
      m_wbyte(st ? 8'h08 : 8'h00, a); m_stop();
      for (int c = 0; c < 8; c++) begin
        {s2, s1, pin} = 3'(c);
        half();
        check("R3 byte0 view", view[7:0], ev(0));
        m_start(); m_wbyte(8'hD3, a); m_rbyte(1'b1, d); m_stop();
        check("R3 byte0 read", d, ev(0));
      end
    end
    s2 = 1'b1; s1 = 1'b1; pin = 1'b1;

    // signature write attempt then wrap in both directions
    wr_seq(12, 2);
    check("R4 signature kept", view[55:48], 8'h13);
    view_all("R8 write wrap");
    rd_seq(12);

    // repeated START in the middle of byte 1
    m_start(); m_wbyte(8'hD2, a); m_wbyte(8'h00, a); m_wbyte(8'h02, a);
    m_wbyte(8'hA0, a); est[0] = 8'hA0 & msk(0);
    for (int i = 0; i < 3; i++) m_bit(1'b0, a);
    m_start(); m_stop();
    view_all("R9 repeated start abort");

    // STOP in the middle of byte 0
    m_start(); m_wbyte(8'hD2, a); m_wbyte(8'h00, a); m_wbyte(8'h02, a);
    for (int i = 0; i < 5; i++) m_bit(1'b1, a);
    m_stop();
    view_all("R9 stop abort");
    check("R11 persistence byte3", view[31:24], est[3]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule